// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It fetches a word from a small internal program store, decodes it, reads two operands from a 32-entry register file and computes a result in an adder/OR unit. It then commits the result at the next rising edge, to the register file or to an internal data store. At that same edge it moves the program counter on. Six operations are supported: add and subtract without overflow traps, OR with a zero-extended constant, word load, word store and branch-on-equal.

The program store is filled through a valid/ready load port, and only while the core is held in reset. `ld_ready` is high exactly while `rst` is high. A word is taken on each rising edge where both `ld_valid` and `ld_ready` are high. A loader facing a low `ld_ready` must hold its word and address until ready returns. When the core runs, ready stays low and the port has no effect.

A debug side exposes the program counter and the register or memory write that the current instruction will commit at the coming edge. A test environment can therefore follow execution one instruction at a time.

Top module: `mlite_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0. No register write or memory write is reported during reset, and the first reads after release return 0.
- R2: `ld_ready` equals `rst`. On an edge where `ld_valid` and `ld_ready` are both high, `ld_data` is stored at program word `ld_addr`. When `ld_valid` is driven while the core runs, the stored program does not change.
- R3: Opcode 000000 with funct 100001 writes rs+rt, and with funct 100011 writes rs-rt, into register rd (bits 15:11). Both are taken modulo 2^32, and the PC advances by 4. rs is bits 25:21 and rt is bits 20:16.
- R4: Opcode 001101 writes rs OR the zero-extended bits 15:0 into register rt.
- R5: Opcode 100011 loads into rt the data word at byte address rs + sign-extended bits 15:0. The word index is address bits [DMEM_AW+1:2].
- R6: Opcode 101011 stores rt at the same kind of address. The store is reported on the debug memory port, and no register is written.
- R7: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate times 4. Otherwise the next PC is PC+4. No write takes place.
- R8: Register 0 always reads 0. A write aimed at it is discarded and is not reported.
- R9: An unknown opcode, or opcode 000000 with an unknown funct, writes nothing and advances the PC by 4.
- R10: During the cycle that an instruction sits at the PC, the debug port shows its pending write. That write is committed at the next rising edge, so one instruction completes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| ld_valid | input | 1 | Program word offered |
| ld_ready | output | 1 | Program word accepted at this edge (high only in reset) |
| ld_addr | input | IMEM_AW (6) | Program word index |
| ld_data | input | 32 | Program word |
| dbg_pc | output | 32 | Current program counter |
| dbg_instr | output | 32 | Instruction fetched at the PC |
| dbg_rf_we | output | 1 | Current instruction writes a register at the next edge |
| dbg_rf_addr | output | 5 | Destination register of that write |
| dbg_rf_data | output | 32 | Value of that write |
| dbg_mem_we | output | 1 | Current instruction stores at the next edge |
| dbg_mem_addr | output | 32 | Byte address of the store or load |
| dbg_mem_data | output | 32 | Data being stored |

## Verification
In this core, a wrong register value stays hidden until an instruction reads it. It shows up as a wrong `dbg_rf_data` or `dbg_mem_addr` in the cycle of that first dependent instruction, so the directed programs read back every result they produce. A wrong PC, a bad branch target or an extra advance shows up one edge later: `dbg_pc` or `dbg_instr` will not match the expected sequence. A bad decode shows up in the same cycle as a missing, extra or misdirected write flag.

// File: rtl/mlite_pkg.sv
package mlite_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADDU  = 6'b100001;
  localparam logic [5:0] FN_SUBU  = 6'b100011;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    use_imm;
    logic    ext_sign;
    alu_op_e alu_op;
    logic    mem_to_reg;
    logic    mem_we;
    logic    branch;
  } ctrl_t;

endpackage

// File: rtl/mlite_decode.sv
module mlite_decode
  import mlite_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        if (funct == FN_ADDU) begin
          ctrl.rf_we  = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.rf_we  = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.rf_we      = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.ext_sign   = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.ext_sign = 1'b1;
        ctrl.alu_op   = ALU_SUB;
        ctrl.branch   = 1'b1;
      end
      default: ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/mlite_regfile.sv
module mlite_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/mlite_alu.sv
module mlite_alu
  import mlite_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mlite_wram.sv
module mlite_wram #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mlite_core.sv
module mlite_core
  import mlite_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IMEM_AW   = $clog2(IMEM_WORDS),
  localparam int DMEM_AW   = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  output logic [XLEN-1:0]    dbg_pc,
  output logic [XLEN-1:0]    dbg_instr,
  output logic               dbg_rf_we,
  output logic [RIDX-1:0]    dbg_rf_addr,
  output logic [XLEN-1:0]    dbg_rf_data,
  output logic               dbg_mem_we,
  output logic [XLEN-1:0]    dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_data
);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dmem_rd, wb_val;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, dst;
  logic [5:0]      f_op, f_fn;
  logic [15:0]     f_imm;
  logic            alu_zero, take_br, rf_we, mem_we;
  ctrl_t           ctrl;

  // program store: written only while held in reset
  assign ld_ready = rst;

  mlite_wram #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk   (clk),
    .we    (ld_valid & rst),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (instr)
  );

  // field split
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  mlite_decode u_dec (
    .op    (f_op),
    .funct (f_fn),
    .ctrl  (ctrl)
  );

  assign dst    = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we  = ctrl.rf_we & ~rst;
  assign mem_we = ctrl.mem_we & ~rst;

  mlite_regfile #(.NREGS(32), .W(XLEN)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (rf_we),
    .wa   (dst),
    .wd   (wb_val)
  );

  assign imm_ext = ctrl.ext_sign ? {{16{f_imm[15]}}, f_imm} : {16'h0000, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  mlite_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  mlite_wram #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (alu_y[DMEM_AW+1:2]),
    .wdata (rt_val),
    .raddr (alu_y[DMEM_AW+1:2]),
    .rdata (dmem_rd)
  );

  assign wb_val = ctrl.mem_to_reg ? dmem_rd : alu_y;

  // next PC
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign take_br   = ctrl.branch & alu_zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // debug view of the instruction in flight
  assign dbg_pc       = pc_q;
  assign dbg_instr    = instr;
  assign dbg_rf_we    = rf_we & (dst != '0);
  assign dbg_rf_addr  = dst;
  assign dbg_rf_data  = wb_val;
  assign dbg_mem_we   = mem_we;
  assign dbg_mem_addr = alu_y;
  assign dbg_mem_data = rt_val;

endmodule

// File: rtl/mlite_core_chk.sv
module mlite_core_chk
  import mlite_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            rf_we,
  input logic [RIDX-1:0] rf_waddr,
  input logic            mem_we
);

  logic [XLEN-1:0] br_off;
  logic            is_beq;
  assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign is_beq = (instr[31:26] == OP_BEQ);

  // R1: reset forces PC to zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc == '0));

  // R1: no writes reported in reset
  a_r1_quiet_reset: assert property (@(posedge clk) rst |-> (!rf_we && !mem_we));

  // R9: every non-branch instruction moves PC by 4
  a_r9_seq_pc: assert property (@(posedge clk) disable iff (rst)
    !is_beq |=> (pc == $past(pc) + 32'd4));

  // R7: branch taken on equal operands
  a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (is_beq && (rs_val == rt_val)) |=> (pc == $past(pc) + 32'd4 + $past(br_off)));

  // R7: branch falls through on unequal operands
  a_r7_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (is_beq && (rs_val != rt_val)) |=> (pc == $past(pc) + 32'd4));

  // R8: register zero is never reported as a destination
  a_r8_no_r0_write: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != '0));

  // R6: a store never writes a register
  a_r6_store_no_rf: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !rf_we);

  // R10: PC stays word aligned
  a_r10_pc_aligned: assert property (@(posedge clk) pc[1:0] == 2'b00);

endmodule

bind mlite_core mlite_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .rf_we    (dbg_rf_we),
  .rf_waddr (dbg_rf_addr),
  .mem_we   (dbg_mem_we)
);

// File: tb/mlite_core_test.sv
module mlite_core_test;

  localparam logic [5:0] OP_R = 6'b000000, OP_ORI = 6'b001101, OP_LW = 6'b100011;
  localparam logic [5:0] OP_SW = 6'b101011, OP_BEQ = 6'b000100;
  localparam logic [5:0] FN_ADD = 6'b100001, FN_SUB = 6'b100011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc, dbg_instr, dbg_rf_data, dbg_mem_addr, dbg_mem_data;
  logic        dbg_rf_we, dbg_mem_we;
  logic [4:0]  dbg_rf_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] prog [64];
  int          plen;

  always #4 clk = ~clk;

  mlite_core uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc), .dbg_instr(dbg_instr),
    .dbg_rf_we(dbg_rf_we), .dbg_rf_addr(dbg_rf_addr), .dbg_rf_data(dbg_rf_data),
    .dbg_mem_we(dbg_mem_we), .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {OP_R, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic exp_rf(string req, logic [31:0] pc, logic [4:0] a, logic [31:0] d);
    check(req, "pc", dbg_pc, pc);
    check(req, "rf_we", {31'b0, dbg_rf_we}, 32'd1);
    check(req, "rf_addr", {27'b0, dbg_rf_addr}, {27'b0, a});
    check(req, "rf_data", dbg_rf_data, d);
    check(req, "mem_we", {31'b0, dbg_mem_we}, 32'd0);
  endtask

  task automatic exp_none(string req, logic [31:0] pc);
    check(req, "pc", dbg_pc, pc);
    check(req, "rf_we", {31'b0, dbg_rf_we}, 32'd0);
    check(req, "mem_we", {31'b0, dbg_mem_we}, 32'd0);
  endtask

  task automatic exp_mem(string req, logic [31:0] pc, logic [31:0] a, logic [31:0] d);
    check(req, "pc", dbg_pc, pc);
    check(req, "mem_we", {31'b0, dbg_mem_we}, 32'd1);
    check(req, "mem_addr", dbg_mem_addr, a);
    check(req, "mem_data", dbg_mem_data, d);
    check(req, "rf_we", {31'b0, dbg_rf_we}, 32'd0);
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  // hold reset, load prog[0..plen-1], release; returns with instruction 0 in flight
  task automatic boot();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      ld_valid = 1'b1;
      ld_addr  = i[5:0];
      ld_data  = prog[i];
      @(negedge clk);
    end
    ld_valid = 1'b0;
    rst      = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #2;
    check("R1", "pc in reset", dbg_pc, 32'd0);
    check("R1", "rf_we in reset", {31'b0, dbg_rf_we}, 32'd0);
    check("R1", "mem_we in reset", {31'b0, dbg_mem_we}, 32'd0);
    check("R2", "ld_ready in reset", {31'b0, ld_ready}, 32'd1);
  endtask

  task automatic t_arith();
    prog[0] = enc_i(OP_ORI, 0, 1, 16'h1234);
    prog[1] = enc_i(OP_ORI, 0, 2, 16'hFFFF);
    prog[2] = enc_r(1, 2, 3, FN_ADD);
    prog[3] = enc_r(1, 2, 4, FN_SUB);
    prog[4] = enc_r(0, 1, 5, FN_SUB);
    prog[5] = enc_r(5, 1, 7, FN_ADD);
    prog[6] = enc_i(OP_ORI, 5, 8, 16'h00F0);
    plen = 7;
    boot();
    check("R2", "ld_ready running", {31'b0, ld_ready}, 32'd0);
    exp_rf("R4", 32'h00, 5'd1, 32'h0000_1234); step();
    exp_rf("R4", 32'h04, 5'd2, 32'h0000_FFFF); step();
    exp_rf("R3", 32'h08, 5'd3, 32'h0001_1233); step();
    exp_rf("R3", 32'h0C, 5'd4, 32'hFFFF_1235); step();
    exp_rf("R3", 32'h10, 5'd5, 32'hFFFF_EDCC); step();
    exp_rf("R3", 32'h14, 5'd7, 32'h0000_0000); step();
    exp_rf("R4", 32'h18, 5'd8, 32'hFFFF_EDFC); step();
    check("R10", "pc after seven", dbg_pc, 32'h1C);
  endtask

  task automatic t_memory();
    prog[0] = enc_i(OP_ORI, 0, 1, 16'h0040);
    prog[1] = enc_i(OP_ORI, 0, 2, 16'hBEEF);
    prog[2] = enc_i(OP_SW, 1, 2, 16'hFFFC);
    prog[3] = enc_i(OP_SW, 1, 1, 16'h0008);
    prog[4] = enc_i(OP_LW, 1, 3, 16'hFFFC);
    prog[5] = enc_i(OP_LW, 1, 4, 16'h0008);
    plen = 6;
    boot();
    step(); step();
    exp_mem("R6", 32'h08, 32'h0000_003C, 32'h0000_BEEF); step();
    exp_mem("R6", 32'h0C, 32'h0000_0048, 32'h0000_0040); step();
    exp_rf("R5", 32'h10, 5'd3, 32'h0000_BEEF);
    check("R5", "load addr", dbg_mem_addr, 32'h0000_003C); step();
    exp_rf("R5", 32'h14, 5'd4, 32'h0000_0040);
  endtask

  task automatic t_branch();
    prog[0] = enc_i(OP_ORI, 0, 1, 16'h0005);
    prog[1] = enc_i(OP_ORI, 0, 2, 16'h0005);
    prog[2] = enc_i(OP_BEQ, 1, 2, 16'h0002);
    prog[3] = enc_i(OP_ORI, 0, 3, 16'hDEAD);
    prog[4] = enc_i(OP_ORI, 0, 3, 16'hDEAD);
    prog[5] = enc_i(OP_BEQ, 1, 0, 16'h0005);
    prog[6] = enc_i(OP_BEQ, 0, 0, 16'hFFF9);
    plen = 7;
    boot();
    step(); step();
    exp_none("R7", 32'h08); step();
    exp_none("R7", 32'h14); step();
    exp_none("R7", 32'h18); step();
    exp_rf("R7", 32'h00, 5'd1, 32'h0000_0005);
  endtask

  task automatic t_zero_nop();
    prog[0] = enc_r(1, 2, 7, FN_ADD);
    prog[1] = enc_i(OP_ORI, 0, 0, 16'h0055);
    prog[2] = {6'b111111, 26'h3FF_FFFF};
    prog[3] = enc_r(0, 0, 9, 6'b100000);
    prog[4] = enc_r(0, 0, 6, FN_ADD);
    prog[5] = enc_i(OP_ORI, 0, 0, 16'h00AA);
    prog[6] = enc_r(0, 0, 6, FN_ADD);
    plen = 7;
    boot();
    exp_rf("R1", 32'h00, 5'd7, 32'h0); step();
    exp_none("R8", 32'h04); step();
    exp_none("R9", 32'h08); step();
    exp_none("R9", 32'h0C); step();
    exp_rf("R8", 32'h10, 5'd6, 32'h0); step();
    step();
    exp_rf("R8", 32'h18, 5'd6, 32'h0);
  endtask

  task automatic t_load_ignored();
    prog[0] = enc_i(OP_ORI, 0, 1, 16'h0001);
    prog[1] = enc_i(OP_ORI, 0, 2, 16'h0002);
    plen = 2;
    boot();
    ld_valid = 1'b1;
    ld_addr  = 6'd1;
    ld_data  = enc_i(OP_ORI, 0, 2, 16'h0077);
    check("R2", "ld_ready while running", {31'b0, ld_ready}, 32'd0);
    exp_rf("R2", 32'h00, 5'd1, 32'h1);
    step();
    ld_valid = 1'b0;
    exp_rf("R2", 32'h04, 5'd2, 32'h2);
    check("R2", "instr kept", dbg_instr, prog[1]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_arith();
    t_memory();
    t_branch();
    t_zero_nop();
    t_load_ignored();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule